// File: doc/BRIEF.md
# Return Address Stack

This block predicts the targets of subroutine returns for an instruction fetch unit. Each time fetch meets a call, the block records the address of the instruction that follows the call, which is the call address plus the instruction size. Each time fetch meets a return, the block offers its newest recorded address as the predicted target and then discards that entry. Entries leave in last-in first-out order, so a return always pairs with the most recent call that has not yet returned.

A return may only be identified once decode has seen it. Until then, fetch follows whatever the branch target buffer predicted. For that case the block has a separate late-return input. In the same cycle it raises a redirect carrying the newest entry as the corrected fetch target, and it discards that entry.

Storage is a circular buffer with a top pointer. When the buffer is full, a new call overwrites the oldest entry. A return on an empty stack raises an invalid-prediction flag and leaves the stack unchanged.

Top module: `ret_addr_stack`

## Requirements
- R1: After synchronous reset the stack is empty: `pred_valid_o`, `bad_pop_o` and `redirect_o` are all 0 while no request is applied.
- R2: A call with address A pushes A+4. From the next cycle `pred_valid_o` is 1 and `pred_target_o` equals A+4.
- R3: Entries come back in last-in first-out order. After the last one is popped, `pred_valid_o` is 0.
- R4: During a cycle with `ret_i` high, `pred_target_o` shows the entry being popped. In the next cycle it shows the entry below.
- R5: During a cycle with `late_ret_i` high on a non-empty stack, `redirect_o` is 1 and `redirect_pc_o` equals the top entry. That entry is popped.
- R6: `ret_i` and `late_ret_i` high in the same cycle together remove exactly one entry.
- R7: After more than DEPTH pushes with no pops, the newest DEPTH return addresses remain and pop out newest first. After DEPTH pops the stack is empty.
- R8: A pop on an empty stack raises `bad_pop_o` in that cycle, keeps `redirect_o` at 0, and leaves the stack empty and usable.
- R9: A call and a return in the same cycle on a non-empty stack replace the top entry with the new return address. The entries beneath are untouched and the depth does not change.
- R10: A call and a return in the same cycle on an empty stack raise `bad_pop_o` and act as a plain push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Fetch saw a call this cycle |
| call_pc_i | input | AW | Address of that call |
| ret_i | input | 1 | Fetch saw a return this cycle |
| late_ret_i | input | 1 | Decode recognised a return that fetch missed |
| pred_target_o | output | AW | Predicted return target (top entry) |
| pred_valid_o | output | 1 | Stack holds at least one entry |
| bad_pop_o | output | 1 | A return arrived while the stack was empty |
| redirect_o | output | 1 | Fetch must restart at `redirect_pc_o` |
| redirect_pc_o | output | AW | Corrected fetch target for a late return |

## Verification
A wrong top pointer shows at `pred_target_o` in the first idle cycle after the faulty update, as a target belonging to a different call. A wrong occupancy count stays hidden until the stack drains. It then shows as `pred_valid_o` dropping too early or too late, or as `bad_pop_o` firing on a stack that is not empty. Overflow faults appear only after a full wrap, when the oldest surviving entry comes out in the wrong place, so the tests push past the depth and then drain every entry.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

    typedef struct packed {
        ras_op_e op;
        logic    bad_pop;
    } ras_dec_t;

    // Decode one cycle of requests against the current emptiness.
    function automatic ras_dec_t decode_req(input logic push, input logic pop,
                                            input logic empty);
        ras_dec_t d;
        d.bad_pop = pop && empty;
        if (push && pop)      d.op = empty ? OP_PUSH : OP_SWAP;
        else if (push)        d.op = OP_PUSH;
        else if (pop && !empty) d.op = OP_POP;
        else                  d.op = OP_IDLE;
        return d;
    endfunction

endpackage

// File: rtl/ras_store.sv
`timescale 1ns/1ps
module ras_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [DEPTH-1:0][AW-1:0] slots;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)                                 slot_q <= '0;
            else if (wr_en && (wr_idx == PW'(i)))    slot_q <= wr_data;
        end
        assign slots[i] = slot_q;
    end

    assign rd_data = slots[rd_idx];

    // R2: a written address is held in the addressed slot afterwards
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ras_ctrl.sv
`timescale 1ns/1ps
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] top_idx,
    output logic          nonempty,
    output logic          bad_pop
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [PW-1:0] ptr_q, ptr_d, ptr_up, ptr_dn;
    logic [CW-1:0] cnt_q, cnt_d;
    ras_dec_t      dec;

    assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    assign dec    = decode_req(push, pop, cnt_q == '0);

    always_comb begin
        ptr_d  = ptr_q;
        cnt_d  = cnt_q;
        wr_en  = 1'b0;
        wr_idx = ptr_up;
        unique case (dec.op)
            OP_PUSH: begin
                wr_en = 1'b1;
                ptr_d = ptr_up;
                cnt_d = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
            end
            OP_SWAP: begin
                wr_en  = 1'b1;
                wr_idx = ptr_q;
            end
            OP_POP: begin
                ptr_d = ptr_dn;
                cnt_d = cnt_q - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_idx  = ptr_q;
    assign nonempty = (cnt_q != '0);
    assign bad_pop  = dec.bad_pop;

    // R7: occupancy never exceeds the depth
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);
    // R8: a lone pop on an empty stack changes nothing
    p_empty_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0) && $stable(ptr_q));
    // R9: simultaneous call and return keep pointer and depth
    p_swap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (push && pop && cnt_q != '0) |=> $stable(ptr_q) && $stable(cnt_q));
    // R2: a plain push below capacity grows the stack by one
    p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && cnt_q < FULL) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ret_addr_stack.sv
`timescale 1ns/1ps
module ret_addr_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int STEP  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic [AW-1:0] call_pc_i,
    input  logic          ret_i,
    input  logic          late_ret_i,
    output logic [AW-1:0] pred_target_o,
    output logic          pred_valid_o,
    output logic          bad_pop_o,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          pop, wr_en, nonempty;
    logic [PW-1:0] wr_idx, top_idx;
    logic [AW-1:0] top_data, link_addr;

    assign pop       = ret_i || late_ret_i;
    assign link_addr = call_pc_i + AW'(STEP);

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .push(call_i), .pop(pop),
        .wr_en(wr_en), .wr_idx(wr_idx), .top_idx(top_idx),
        .nonempty(nonempty), .bad_pop(bad_pop_o)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(link_addr), .rd_idx(top_idx), .rd_data(top_data)
    );

    assign pred_target_o = top_data;
    assign pred_valid_o  = nonempty;
    assign redirect_o    = late_ret_i && nonempty;
    assign redirect_pc_o = top_data;

    // R5: a late return on a filled stack always redirects
    p_late_redirect_r5: assert property (@(posedge clk) disable iff (rst)
        (late_ret_i && pred_valid_o) |-> redirect_o);
    // R8: an empty-stack pop never redirects
    p_no_redirect_empty_r8: assert property (@(posedge clk) disable iff (rst)
        bad_pop_o |-> !redirect_o);

endmodule

// File: tb/ret_addr_stack_bench.sv
`timescale 1ns/1ps
module ret_addr_stack_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          call_i = 1'b0, ret_i = 1'b0, late_ret_i = 1'b0;
    logic [AW-1:0] call_pc_i = '0;
    logic [AW-1:0] pred_target_o, redirect_pc_o;
    logic          pred_valid_o, bad_pop_o, redirect_o;

    int total = 0;
    int bad   = 0;

    logic [AW-1:0] s_tgt, s_rpc;
    logic          s_val, s_bad, s_redir;

    always #10 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .AW(AW), .STEP(4)) u_ret_addr_stack (
        .clk(clk), .rst(rst), .call_i(call_i), .call_pc_i(call_pc_i),
        .ret_i(ret_i), .late_ret_i(late_ret_i),
        .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o),
        .bad_pop_o(bad_pop_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o)
    );

    // Drive one cycle of requests at the falling edge, sample shortly after.
    task automatic cyc(input logic c, input logic [AW-1:0] pc,
                       input logic r, input logic l);
        @(negedge clk);
        call_i = c; call_pc_i = pc; ret_i = r; late_ret_i = l;
        #2;
        s_tgt = pred_target_o; s_val = pred_valid_o; s_bad = bad_pop_o;
        s_redir = redirect_o; s_rpc = redirect_pc_o;
    endtask

    task automatic chk(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        cyc(0, '0, 0, 0);
        chk("R1 valid", AW'(s_val), 0);
        chk("R1 bad_pop", AW'(s_bad), 0);
        chk("R1 redirect", AW'(s_redir), 0);
    endtask

    task automatic t_push_pop;
        cyc(1, 32'h100, 0, 0);
        cyc(0, '0, 0, 0);
        chk("R2 valid", AW'(s_val), 1);
        chk("R2 target", s_tgt, 32'h104);
        cyc(1, 32'h200, 0, 0);
        cyc(0, '0, 0, 0);
        chk("R2 second target", s_tgt, 32'h204);
        cyc(0, '0, 1, 0);
        chk("R4 target during pop", s_tgt, 32'h204);
        cyc(0, '0, 0, 0);
        chk("R3 lifo next", s_tgt, 32'h104);
        cyc(0, '0, 1, 0);
        chk("R4 last target", s_tgt, 32'h104);
        cyc(0, '0, 0, 0);
        chk("R3 drained", AW'(s_val), 0);
    endtask

    task automatic t_late;
        cyc(1, 32'h300, 0, 0);
        cyc(1, 32'h400, 0, 0);
        cyc(0, '0, 0, 1);
        chk("R5 redirect", AW'(s_redir), 1);
        chk("R5 redirect pc", s_rpc, 32'h404);
        cyc(0, '0, 0, 0);
        chk("R5 popped", s_tgt, 32'h304);
        chk("R5 no redirect idle", AW'(s_redir), 0);
        cyc(0, '0, 0, 1);
        chk("R5 second redirect pc", s_rpc, 32'h304);
        cyc(0, '0, 0, 0);
        chk("R5 drained", AW'(s_val), 0);
    endtask

    task automatic t_both;
        cyc(1, 32'h500, 0, 0);
        cyc(1, 32'h600, 0, 0);
        cyc(0, '0, 1, 1);
        chk("R6 target", s_tgt, 32'h604);
        cyc(0, '0, 0, 0);
        chk("R6 one pop", s_tgt, 32'h504);
        chk("R6 still valid", AW'(s_val), 1);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        chk("R6 drained", AW'(s_val), 0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < DEPTH + 2; i++) cyc(1, 32'h1000 + AW'(i * 16), 0, 0);
        for (int k = 0; k < DEPTH; k++) begin
            cyc(0, '0, 1, 0);
            chk("R7 order", s_tgt, 32'h1000 + AW'((DEPTH + 1 - k) * 16) + 4);
        end
        cyc(0, '0, 0, 0);
        chk("R7 empty after depth pops", AW'(s_val), 0);
    endtask

    task automatic t_empty;
        cyc(0, '0, 1, 0);
        chk("R8 bad_pop fetch", AW'(s_bad), 1);
        cyc(0, '0, 0, 1);
        chk("R8 bad_pop late", AW'(s_bad), 1);
        chk("R8 no redirect", AW'(s_redir), 0);
        cyc(0, '0, 0, 0);
        chk("R8 still empty", AW'(s_val), 0);
        chk("R8 flag clears", AW'(s_bad), 0);
        cyc(1, 32'h700, 0, 0);
        cyc(0, '0, 0, 0);
        chk("R8 usable after", s_tgt, 32'h704);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        chk("R8 drained", AW'(s_val), 0);
    endtask

    task automatic t_swap;
        cyc(1, 32'h800, 0, 0);
        cyc(1, 32'h900, 0, 0);
        cyc(1, 32'hA00, 1, 0);
        chk("R9 target before swap", s_tgt, 32'h904);
        chk("R9 no bad_pop", AW'(s_bad), 0);
        cyc(0, '0, 0, 0);
        chk("R9 replaced", s_tgt, 32'hA04);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        chk("R9 below untouched", s_tgt, 32'h804);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        chk("R9 depth kept", AW'(s_val), 0);
    endtask

    task automatic t_swap_empty;
        cyc(1, 32'hB00, 1, 0);
        chk("R10 bad_pop", AW'(s_bad), 1);
        cyc(0, '0, 0, 0);
        chk("R10 pushed valid", AW'(s_val), 1);
        chk("R10 pushed target", s_tgt, 32'hB04);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 0);
        chk("R10 drained", AW'(s_val), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_push_pop();
        t_late();
        t_both();
        t_overflow();
        t_empty();
        t_swap();
        t_swap_empty();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule